// File: doc/BRIEF.md
# GPIO Output and Input Data Register Bank

This block holds the data side of a 32-pin general-purpose port behind a simple memory-mapped bus. An output latch drives the pins directly. Software may overwrite the whole latch, or it may change only the chosen bits through three write-only alias addresses. One alias forces bits to 1, one forces bits to 0 and one inverts bits. Because each alias changes only the bits written as 1, no read-modify-write sequence is needed, and two agents that work on different pins cannot corrupt each other's bits.

The pin levels pass through a two-stage synchronizer and can be read back at a separate read-only address. The bus has no handshake. A write takes effect at the clock edge on which `bus_we` is high. Read data is a combinational function of the address, so every access finishes in a single cycle. Direction control, pin multiplexing and interrupts are handled outside this block.

Top module: `pin_data_regs`

## Requirements
- R1: While `rst` is high at a rising edge, the output latch and both synchronizer stages clear to zero. A read of offset 0x00 or 0x10 then returns 0, and `pin_out` is 0.
- R2: A write to offset 0x00 loads `bus_wdata` into the latch at that edge. A read of offset 0x00 returns the latch value.
- R3: A write to offset 0x04 sets each latch bit whose `bus_wdata` bit is 1. Every other latch bit keeps its value.
- R4: A write to offset 0x08 clears each latch bit whose `bus_wdata` bit is 1. Every other latch bit keeps its value.
- R5: A write to offset 0x0C inverts each latch bit whose `bus_wdata` bit is 1. Every other latch bit keeps its value.
- R6: A read of offset 0x04, 0x08 or 0x0C returns zero.
- R7: A read of offset 0x10 returns the `pin_in` value that was sampled two rising edges earlier. A change on `pin_in` is not visible after only one edge.
- R8: A write to offset 0x10, or to any address not listed above (0x14 to 0x1F, or an address whose low two bits are not zero), leaves the latch unchanged. A read of an unlisted address returns zero.
- R9: `pin_out` always equals the latch. It changes only at the edge of a write to offsets 0x00 to 0x0C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output latch driving the pins |

## Verification
Directed patterns apply each alias to a latch that holds a mix of ones and zeros, with write data that overlaps those bits only in part. A masked-bit error therefore shows up as a wrong bit value and cannot look like a whole-word overwrite. All-ones and all-zero write data expose aliases that ignore the mask or that write the data through unchanged. A random mix of writes to every address, including the input register and unmapped addresses, is compared against a reference model and tells apart the set, clear and toggle behaviours and the ignored writes. Pin changes are read one edge and two edges later, which distinguishes a two-stage synchronizer from a one-stage one or a missing one.

// File: rtl/pin_data_pkg.sv
package pin_data_pkg;

    localparam int PIN_COUNT = 32;
    localparam int BUS_AW    = 5;

    localparam int OFS_DATA = 'h00;
    localparam int OFS_SET  = 'h04;
    localparam int OFS_CLR  = 'h08;
    localparam int OFS_TOG  = 'h0C;
    localparam int OFS_IN   = 'h10;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_SET,
        SEL_CLR,
        SEL_TOG,
        SEL_IN
    } reg_sel_e;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_LOAD,
        OP_SET,
        OP_CLR,
        OP_TOG
    } latch_op_e;

    typedef struct packed {
        reg_sel_e  sel;
        latch_op_e op;
    } bus_dec_t;

    function automatic latch_op_e op_of_sel(input reg_sel_e s, input logic we);
        if (!we) return OP_HOLD;
        case (s)
            SEL_DATA: return OP_LOAD;
            SEL_SET:  return OP_SET;
            SEL_CLR:  return OP_CLR;
            SEL_TOG:  return OP_TOG;
            default:  return OP_HOLD;
        endcase
    endfunction

endpackage

// File: rtl/pin_bus_decode.sv
module pin_bus_decode
    import pin_data_pkg::*;
#(
    parameter int ADDR_W = BUS_AW
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output bus_dec_t          dec
);

    reg_sel_e sel;

    always_comb begin
        if (addr == ADDR_W'(OFS_DATA))      sel = SEL_DATA;
        else if (addr == ADDR_W'(OFS_SET))  sel = SEL_SET;
        else if (addr == ADDR_W'(OFS_CLR))  sel = SEL_CLR;
        else if (addr == ADDR_W'(OFS_TOG))  sel = SEL_TOG;
        else if (addr == ADDR_W'(OFS_IN))   sel = SEL_IN;
        else                                sel = SEL_NONE;
    end

    always_comb begin
        dec.sel = sel;
        dec.op  = op_of_sel(sel, we);
    end

endmodule

// File: rtl/pin_in_sync.sv
module pin_in_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= async_in;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[g] <= '0;
            else     stage_q[g] <= stage_q[g-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/pin_out_latch.sv
module pin_out_latch
    import pin_data_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  latch_op_e        op,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] q_next;

    always_comb begin
        case (op)
            OP_LOAD: q_next = wdata;
            OP_SET:  q_next = q | wdata;
            OP_CLR:  q_next = q & ~wdata;
            OP_TOG:  q_next = q ^ wdata;
            default: q_next = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q_next;
    end

endmodule

// File: rtl/pin_data_regs.sv
module pin_data_regs
    import pin_data_pkg::*;
#(
    parameter int PIN_W       = PIN_COUNT,
    parameter int ADDR_W      = BUS_AW,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [PIN_W-1:0]  bus_wdata,
    output logic [PIN_W-1:0]  bus_rdata,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out
);

    bus_dec_t         dec;
    logic [PIN_W-1:0] latch_q;
    logic [PIN_W-1:0] in_sync;

    pin_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .we   (bus_we),
        .dec  (dec)
    );

    pin_out_latch #(.WIDTH(PIN_W)) u_latch (
        .clk   (clk),
        .rst   (rst),
        .op    (dec.op),
        .wdata (bus_wdata),
        .q     (latch_q)
    );

    pin_in_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (in_sync)
    );

    always_comb begin
        case (dec.sel)
            SEL_DATA: bus_rdata = latch_q;
            SEL_IN:   bus_rdata = in_sync;
            default:  bus_rdata = '0;
        endcase
    end

    assign pin_out = latch_q;

endmodule

// File: rtl/pin_data_regs_chk.sv
module pin_data_regs_chk #(
    parameter int PIN_W  = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [PIN_W-1:0]  bus_wdata,
    input logic [PIN_W-1:0]  bus_rdata,
    input logic [PIN_W-1:0]  pin_in,
    input logic [PIN_W-1:0]  pin_out
);

    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'('h00);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'('h04);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'('h08);
    localparam logic [ADDR_W-1:0] A_TOG  = ADDR_W'('h0C);
    localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'('h10);

    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)              age <= '0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    logic wr_latch;
    assign wr_latch = bus_we && (bus_addr == A_DATA || bus_addr == A_SET ||
                                 bus_addr == A_CLR  || bus_addr == A_TOG);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_out == '0));

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_DATA) |=> (pin_out == $past(bus_wdata)));

    assert_set_bits_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_SET) |=> (pin_out == ($past(pin_out) | $past(bus_wdata))));

    assert_clear_bits_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_CLR) |=> (pin_out == ($past(pin_out) & ~$past(bus_wdata))));

    assert_toggle_bits_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_TOG) |=> (pin_out == ($past(pin_out) ^ $past(bus_wdata))));

    assert_alias_read_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_SET || bus_addr == A_CLR || bus_addr == A_TOG) |-> (bus_rdata == '0));

    assert_input_delay_R7: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2 && bus_addr == A_IN) |-> (bus_rdata == $past(pin_in, 2)));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !wr_latch |=> $stable(pin_out));

    assert_readback_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_DATA) |-> (bus_rdata == pin_out));

endmodule

bind pin_data_regs pin_data_regs_chk #(.PIN_W(PIN_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out)
);

// File: tb/sim_pin_data_regs.sv
module sim_pin_data_regs;

    localparam int W  = 32;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  bus_rdata;
    logic [W-1:0]  pin_in = '1;
    logic [W-1:0]  pin_out;

    int total = 0;
    int bad   = 0;
    logic [W-1:0] model = '0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pin_data_regs u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out)
    );

    function automatic logic [W-1:0] next_model(input logic [AW-1:0] a,
                                                input logic [W-1:0] cur,
                                                input logic [W-1:0] d);
        case (a)
            5'h00:   return d;
            5'h04:   return cur | d;
            5'h08:   return cur & ~d;
            5'h0C:   return cur ^ d;
            default: return cur;
        endcase
    endfunction

    function automatic bit is_zero_read(input logic [AW-1:0] a);
        return !(a == 5'h00 || a == 5'h10);
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        model = next_model(a, model, d);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] d);
        bus_addr = a; bus_we = 1'b0;
        #1;
        d = bus_rdata;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [W-1:0] r;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state while reset is held, pins all high
        check("R1 pin_out", pin_out, '0);
        rd(5'h00, r); check("R1 data read", r, '0);
        rd(5'h10, r); check("R1 input read", r, '0);
        rst = 1'b0;

        // R2 load, R9 readback
        wr(5'h00, 32'hA5A5_0F0F);
        check("R2 load pin_out", pin_out, 32'hA5A5_0F0F);
        rd(5'h00, r); check("R9 readback", r, 32'hA5A5_0F0F);
        // R3 set with partial overlap
        wr(5'h04, 32'h0FF0_00FF);
        check("R3 set", pin_out, 32'hAFF5_0FFF);
        // R4 clear with partial overlap
        wr(5'h08, 32'h3C3C_3C3C);
        check("R4 clear", pin_out, 32'h83C1_03C3);
        // R5 toggle
        wr(5'h0C, 32'hFFFF_0000);
        check("R5 toggle", pin_out, 32'h7C3E_03C3);
        // zero data on aliases has no effect
        wr(5'h04, 32'h0); wr(5'h08, 32'h0); wr(5'h0C, 32'h0);
        check("R3 R4 R5 zero mask", pin_out, 32'h7C3E_03C3);
        // all ones
        wr(5'h0C, '1); check("R5 toggle all", pin_out, 32'h83C1_FC3C);
        wr(5'h04, '1); check("R3 set all", pin_out, '1);
        wr(5'h08, '1); check("R4 clear all", pin_out, '0);
        // R6 alias reads
        wr(5'h00, 32'hDEAD_BEEF);
        rd(5'h04, r); check("R6 set read", r, '0);
        rd(5'h08, r); check("R6 clr read", r, '0);
        rd(5'h0C, r); check("R6 tog read", r, '0);
        // R8 writes to input and unmapped addresses ignored
        wr(5'h10, 32'h1234_5678); check("R8 input write", pin_out, 32'hDEAD_BEEF);
        wr(5'h14, 32'h0); check("R8 unmapped write", pin_out, 32'hDEAD_BEEF);
        wr(5'h05, 32'hFFFF_FFFF); check("R8 misaligned write", pin_out, 32'hDEAD_BEEF);
        rd(5'h1C, r); check("R8 unmapped read", r, '0);

        // R7 synchronizer latency
        @(negedge clk);
        pin_in = 32'h0000_0000;
        repeat (2) @(negedge clk);
        pin_in = 32'hC0FF_EE11;
        @(negedge clk);
        rd(5'h10, r); check("R7 one edge old", r, 32'h0000_0000);
        @(negedge clk);
        rd(5'h10, r); check("R7 two edges new", r, 32'hC0FF_EE11);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0] a;
            logic [W-1:0] d;
            logic [W-1:0] p;
            int k;
            k = $urandom_range(0, 9);
            case (k)
                0, 1: a = 5'h00;
                2, 3: a = 5'h04;
                4, 5: a = 5'h08;
                6, 7: a = 5'h0C;
                8:    a = 5'h10;
                default: a = AW'($urandom_range(0, 31));
            endcase
            d = $urandom();
            wr(a, d);
            check("R2 R3 R4 R5 R8 random latch", pin_out, model);
            rd(5'h00, r); check("R9 random readback", r, model);
            a = AW'($urandom_range(0, 31));
            rd(a, r);
            if (is_zero_read(a)) check("R6 R8 random zero read", r, '0);
            if ((i % 8) == 0) begin
                p = $urandom();
                @(negedge clk);
                pin_in = p;
                repeat (2) @(negedge clk);
                rd(5'h10, r); check("R7 random input", r, p);
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule